// File: doc/BRIEF.md
# Oscillator Tuning Register Loader

This block sits between a host processor and the phase-accumulator core of a numerically controlled oscillator. The host owns a 16-bit data bus, a 3-bit address and an active-low write strobe. With them it sets two 32-bit tuning words and four 12-bit phase offsets. The oscillator core reads all six values every cycle of its own clock. Each tuning word is filled as two independent 16-bit halves. A phase offset takes only the low twelve data bits of its write.

The strobe is asynchronous to the oscillator clock. Address and data are latched on the strobe's rising edge into a holding stage, and a toggle flag flips at the same time. The flag crosses into the oscillator domain through a flop chain. When the synchronised flag changes, the addressed register or register half takes the held value. The other registers keep their contents. An asynchronous active-low reset, released in step with the oscillator clock, zeroes every register.

Top module: `nco_load_bank`

## Requirements
- R1: While reset is asserted, and after its synchronous release until the first write, all six register outputs read zero.
- R2: A write to address 3'b000 loads data into bits 15:0 of tuning word 0, and 3'b001 loads bits 31:16; the other half keeps its value.
- R3: A write to address 3'b010 loads bits 15:0 of tuning word 1, and 3'b011 loads bits 31:16; the other half keeps its value.
- R4: Addresses 3'b100, 3'b101, 3'b110 and 3'b111 load phase offsets 0, 1, 2 and 3 with data bits 11:0.
- R5: On a phase offset write, data bits 15:12 have no effect on any output.
- R6: Address and data are taken at the rising edge of the write strobe. Bus values that are present only while the strobe is low before that edge, or that appear after it, are not loaded.
- R7: A write has not yet changed any output at the first oscillator clock edge after the strobe rises, and is visible by the fourth edge (SYNC_STAGES+2 with the default of 2). It changes only the addressed register or half.
- R8: With the strobe held high, activity on the address and data bus leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_n | input | 1 | Host write strobe, active low; latched on its rising edge |
| host_addr | input | 3 | Host register address |
| host_data | input | 16 | Host write data |
| tune0 | output | 32 | Tuning word 0 |
| tune1 | output | 32 | Tuning word 1 |
| phase0 | output | 12 | Phase offset 0 |
| phase1 | output | 12 | Phase offset 1 |
| phase2 | output | 12 | Phase offset 2 |
| phase3 | output | 12 | Phase offset 3 |

## Verification
The assertions assume the host leaves at least SYNC_STAGES+2 oscillator clock periods between rising strobe edges. Under that spacing, one synchronised update pulse never follows another in the next cycle, and the held address and data stay still while the oscillator domain uses them. The bench meets this by waiting six clock periods after every strobe. It places each strobe at a random offset within the oscillator clock period. It also drives junk on the bus while the strobe is low before the valid value appears, and again after the strobe has risen.

// File: rtl/nco_load_pkg.sv
`timescale 1ns/1ps
package nco_load_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int FREQ_W  = 2 * DATA_W;
  localparam int PHASE_W = 12;
  localparam int N_FREQ  = 2;
  localparam int N_PHASE = 4;
  localparam int HALF_W  = FREQ_W / 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } host_wr_t;

  typedef logic [N_FREQ-1:0][FREQ_W-1:0]   tune_arr_t;
  typedef logic [N_PHASE-1:0][PHASE_W-1:0] phase_arr_t;
endpackage

// File: rtl/nco_rst_sync.sv
`timescale 1ns/1ps
module nco_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/nco_wr_capture.sv
`timescale 1ns/1ps
module nco_wr_capture
  import nco_load_pkg::*;
(
  input  logic              wr_n,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output host_wr_t          held,
  output logic              flag
);
  host_wr_t held_d;
  logic     flag_d;

  always_comb begin
    held_d.addr = addr;
    held_d.data = data;
    flag_d      = ~flag;
  end

  always_ff @(posedge wr_n or negedge arst_n) begin
    if (!arst_n) begin
      held <= '0;
      flag <= 1'b0;
    end else begin
      held <= held_d;
      flag <= flag_d;
    end
  end
endmodule

// File: rtl/nco_flag_sync.sv
`timescale 1ns/1ps
module nco_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  output logic pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], flag_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign pulse = sh_q[STAGES] ^ sh_q[STAGES-1];

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/nco_reg_file.sv
`timescale 1ns/1ps
module nco_reg_file
  import nco_load_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  host_wr_t   wr,
  output tune_arr_t  tune_q,
  output phase_arr_t phase_q
);
  logic                     sel_phase;
  logic [N_FREQ-1:0]        tune_lo_en;
  logic [N_FREQ-1:0]        tune_hi_en;
  logic [N_PHASE-1:0]       phase_en;
  tune_arr_t                tune_d;
  phase_arr_t               phase_d;

  assign sel_phase = wr.addr[ADDR_W-1];

  for (genvar f = 0; f < N_FREQ; f++) begin : g_tune
    always_comb begin
      tune_lo_en[f] = upd && !sel_phase && (wr.addr[1] == f[0]) && !wr.addr[0];
      tune_hi_en[f] = upd && !sel_phase && (wr.addr[1] == f[0]) &&  wr.addr[0];
      tune_d[f]     = tune_q[f];
      if (tune_lo_en[f]) tune_d[f][HALF_W-1:0]      = wr.data;
      if (tune_hi_en[f]) tune_d[f][FREQ_W-1:HALF_W] = wr.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tune_q[f] <= '0;
      else if (tune_lo_en[f] || tune_hi_en[f]) tune_q[f] <= tune_d[f];
    end
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    always_comb begin
      phase_en[p] = upd && sel_phase && (wr.addr[1:0] == p[1:0]);
      phase_d[p]  = wr.data[PHASE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase_q[p] <= '0;
      else if (phase_en[p]) phase_q[p] <= phase_d[p];
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(tune_q) && $stable(phase_q)));

  // R4
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sel_phase) |=> (phase_q[$past(wr.addr[1:0])] == $past(wr.data[PHASE_W-1:0])));

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !sel_phase && !wr.addr[0]) |=>
      (tune_q[$past(wr.addr[1])][FREQ_W-1:HALF_W] == $past(tune_q[wr.addr[1]][FREQ_W-1:HALF_W])));

  // R3
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !sel_phase && wr.addr[0]) |=>
      (tune_q[$past(wr.addr[1])][HALF_W-1:0] == $past(tune_q[wr.addr[1]][HALF_W-1:0])));
endmodule

// File: rtl/nco_load_bank.sv
`timescale 1ns/1ps
module nco_load_bank
  import nco_load_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_data,
  output logic [FREQ_W-1:0]  tune0,
  output logic [FREQ_W-1:0]  tune1,
  output logic [PHASE_W-1:0] phase0,
  output logic [PHASE_W-1:0] phase1,
  output logic [PHASE_W-1:0] phase2,
  output logic [PHASE_W-1:0] phase3
);
  logic       srst_n;
  host_wr_t   held;
  logic       flag;
  logic       upd;
  tune_arr_t  tune_q;
  phase_arr_t phase_q;

  nco_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nco_wr_capture u_capture (
    .wr_n   (host_wr_n),
    .arst_n (rst_n),
    .addr   (host_addr),
    .data   (host_data),
    .held   (held),
    .flag   (flag)
  );

  nco_flag_sync #(.STAGES(SYNC_STAGES)) u_flag_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .flag_in (flag),
    .pulse   (upd)
  );

  nco_reg_file u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .upd     (upd),
    .wr      (held),
    .tune_q  (tune_q),
    .phase_q (phase_q)
  );

  assign tune0  = tune_q[0];
  assign tune1  = tune_q[1];
  assign phase0 = phase_q[0];
  assign phase1 = phase_q[1];
  assign phase2 = phase_q[2];
  assign phase3 = phase_q[3];

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> (tune_q == '0 && phase_q == '0));
endmodule

// File: tb/nco_load_bank_bench.sv
`timescale 1ns/1ps
module nco_load_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic [31:0] tune0, tune1;
  logic [11:0] phase0, phase1, phase2, phase3;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_t [2];
  logic [11:0] exp_p [4];

  always #2 clk = ~clk;

  nco_load_bank u_nco_load_bank (
    .clk(clk), .rst_n(rst_n), .host_wr_n(wr_n), .host_addr(addr), .host_data(data),
    .tune0(tune0), .tune1(tune1),
    .phase0(phase0), .phase1(phase1), .phase2(phase2), .phase3(phase3)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "tune0", tune0, exp_t[0]);
    chk(req, "tune1", tune1, exp_t[1]);
    chk(req, "phase0", {20'd0, phase0}, {20'd0, exp_p[0]});
    chk(req, "phase1", {20'd0, phase1}, {20'd0, exp_p[1]});
    chk(req, "phase2", {20'd0, phase2}, {20'd0, exp_p[2]});
    chk(req, "phase3", {20'd0, phase3}, {20'd0, exp_p[3]});
  endtask

  task automatic clear_model();
    exp_t[0] = '0; exp_t[1] = '0;
    for (int i = 0; i < 4; i++) exp_p[i] = '0;
  endtask

  // One host write at a random offset in the clock period; junk on the bus
  // while the strobe is low before valid data and again after the rise (R6).
  task automatic host_write(input logic [2:0] a, input logic [15:0] d, input string req);
    int skew_ps;
    skew_ps = 100 + int'($urandom_range(0, 3800));
    @(negedge clk);
    #(skew_ps / 1000.0);
    wr_n = 1'b0;
    addr = ~a;
    data = ~d;
    #1.5;
    addr = a;
    data = d;
    #1.5;
    wr_n = 1'b1;
    #0.5;
    addr = $urandom_range(0, 7);
    data = $urandom_range(0, 16'hFFFF);
    // R7: nothing has changed at the first edge after the rise
    @(posedge clk);
    #1;
    chk_all("R7");
    if (a[2]) exp_p[a[1:0]] = d[11:0];
    else if (a[0]) exp_t[a[1]][31:16] = d;
    else exp_t[a[1]][15:0] = d;
    // R7: visible by the fourth edge
    repeat (3) @(posedge clk);
    #1;
    chk_all(req);
    repeat (2) @(posedge clk);
  endtask

  function automatic string req_of(input logic [2:0] a);
    if (a[2]) return "R4";
    if (a[1]) return "R3";
    return "R2";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
    clear_model();
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_all("R1");

    // R2 R3 R4 sweep: fixed patterns then random values at every address
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < 4; k++) host_write(3'(a), pats[k], req_of(3'(a)));
      for (int k = 0; k < 6; k++) host_write(3'(a), 16'($urandom_range(0, 16'hFFFF)), req_of(3'(a)));
    end

    // R5: upper nibble differs, low 12 bits equal -> phase equals the low bits
    for (int a = 4; a < 8; a++) begin
      host_write(3'(a), 16'h0ABC, "R5");
      host_write(3'(a), 16'hFABC, "R5");
      host_write(3'(a), 16'h7123, "R5");
    end

    // R2 R3: half-by-half assembly of both tuning words
    host_write(3'b000, 16'h1234, "R2");
    host_write(3'b001, 16'h89AB, "R2");
    host_write(3'b010, 16'hCDEF, "R3");
    host_write(3'b011, 16'h4567, "R3");

    // R8: bus activity with the strobe high
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      addr = 3'(i);
      data = 16'($urandom_range(0, 16'hFFFF));
    end
    repeat (4) @(posedge clk);
    #1;
    chk_all("R8");

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    clear_model();
    chk_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_all("R1");
    host_write(3'b101, 16'hF00D, "R4");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule